// File: doc/BRIEF.md
# Sequential Remainder by a Mersenne Divisor

This unit computes the remainder of a 32-bit unsigned operand divided by d = 2^S − 1, where S is a compile-time parameter (1 to 16). It does not divide. It uses the fact that 2^S ≡ 1 modulo d: it cuts the value into S-bit digits, adds the digits, and folds the sum again whenever the sum is still larger than d. When folding stops, a value equal to d is reported as zero.

The number of folding passes depends on the operand, so a small sequencer runs the work. It adds one digit per clock cycle, compares the sum against d, and then either starts a new pass on the sum or publishes the result. A caller pulses `start` with the operand while the unit is idle. Some cycles later it receives a one-cycle `done` pulse, and `remainder` is valid in that cycle. `remainder` then holds its value until the next result.

Top module: `mersenne_mod_seq`

## Requirements
- R1: After a synchronous reset, `done` is 0 and `remainder` is 0.
- R2: For any 32-bit operand, the `remainder` shown with `done` equals operand modulo (2^S − 1).
- R3: `remainder` always lies in 0..d−1. An operand that is an exact multiple of d, including d itself, yields 0.
- R4: Each accepted `start` produces exactly one `done`, and `done` is high for exactly one cycle.
- R5: A `start` pulse that arrives while a computation is in progress is ignored. No extra `done` appears, and the result is the one for the operand captured first.
- R6: An operand below 2^S (a single digit) completes with `done` high in the cycle that follows the third rising edge, counting the edge that samples `start` as the first.
- R7: `remainder` keeps its value in every cycle in which `done` is low.
- R8: An operand of 0 yields a remainder of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a computation; accepted only when idle |
| operand | input | OPW (32) | Unsigned value, captured with an accepted start |
| done | output | 1 | One-cycle pulse when `remainder` is new |
| remainder | output | S | Operand modulo 2^S − 1 |

## Verification
The assertions assume that `start` is sampled only when it is high for a single cycle, and that S stays within 1..16. Under those conditions the digit sum of any 32-bit value is bounded by the accumulator width. The bench drives `start` and `operand` on the falling edge, always as one-cycle pulses. It places the ignored second pulse two cycles into a multi-digit computation, when every instance is still adding digits. Three instances with S = 2, 3 and 5 receive the same stimulus, and each result is compared against the `%` operator.

// File: rtl/mmod_pkg.sv
package mmod_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACC   = 2'd1,
    ST_CHECK = 2'd2,
    ST_FIN   = 2'd3
  } mmod_state_t;

endpackage

// File: rtl/mmod_fold.sv
module mmod_fold #(
  parameter int OPW  = 32,
  parameter int S    = 2,
  parameter int ACCW = 6,
  parameter int MAXSUM = 48
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_op,
  input  logic            reload,
  input  logic            acc_en,
  input  logic [OPW-1:0]  operand,
  output logic [ACCW-1:0] sum_q,
  output logic            last,
  output logic            over_d
);

  localparam logic [ACCW-1:0] DIV = ACCW'({S{1'b1}});
  localparam logic [ACCW-1:0] SUM_LIMIT = ACCW'(MAXSUM);

  logic [OPW-1:0] work_q;
  logic [OPW-1:0] work_shift;

  assign work_shift = work_q >> S;
  assign last       = (work_shift == '0);
  assign over_d     = (sum_q > DIV);

  always_ff @(posedge clk) begin
    if (rst) begin
      work_q <= '0;
      sum_q  <= '0;
    end else if (load_op) begin
      work_q <= operand;
      sum_q  <= '0;
    end else if (reload) begin
      work_q <= OPW'(sum_q);
      sum_q  <= '0;
    end else if (acc_en) begin
      work_q <= work_shift;
      sum_q  <= sum_q + ACCW'(work_q[S-1:0]);
    end
  end

  AST_SUM_BOUND: assert property (@(posedge clk) disable iff (rst)
    acc_en |=> (sum_q <= SUM_LIMIT)); // R2

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (load_op || reload) |=> (sum_q == '0)); // R2

endmodule

// File: rtl/mmod_ctrl.sv
module mmod_ctrl
  import mmod_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        last,
  input  logic        over_d,
  output logic        load_op,
  output logic        acc_en,
  output logic        reload,
  output logic        capture,
  output mmod_state_t state_q
);

  mmod_state_t state_d;

  assign load_op = (state_q == ST_IDLE) && start;
  assign acc_en  = (state_q == ST_ACC);
  assign reload  = (state_q == ST_CHECK) && over_d;
  assign capture = (state_q == ST_CHECK) && !over_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_ACC;
      ST_ACC:   if (last)  state_d = ST_CHECK;
      ST_CHECK: state_d = over_d ? ST_ACC : ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACC) |=> (state_q == ST_ACC || state_q == ST_CHECK)); // R5

  AST_FIN_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FIN) |=> (state_q == ST_IDLE)); // R4

endmodule

// File: rtl/mmod_result.sv
module mmod_result #(
  parameter int S    = 2,
  parameter int ACCW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            capture,
  input  logic [ACCW-1:0] sum,
  output logic            done,
  output logic [S-1:0]    remainder
);

  localparam logic [ACCW-1:0] DIV = ACCW'({S{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      remainder <= '0;
    end else begin
      done <= capture;
      if (capture) remainder <= (sum == DIV) ? '0 : sum[S-1:0];
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4

  AST_REM_RANGE: assert property (@(posedge clk) disable iff (rst)
    done |-> (remainder != {S{1'b1}})); // R3

  AST_REM_STABLE: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(remainder)); // R7

endmodule

// File: rtl/mersenne_mod_seq.sv
module mersenne_mod_seq #(
  parameter int OPW = 32,
  parameter int S   = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [OPW-1:0] operand,
  output logic           done,
  output logic [S-1:0]   remainder
);
  import mmod_pkg::*;

  localparam int NCHUNK = (OPW + S - 1) / S;
  localparam int MAXSUM = NCHUNK * ((1 << S) - 1);
  localparam int ACCW   = $clog2(MAXSUM + 1);

  logic            load_op, acc_en, reload, capture;
  logic            last, over_d;
  logic [ACCW-1:0] sum_q;
  mmod_state_t     state_q;

  mmod_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .last    (last),
    .over_d  (over_d),
    .load_op (load_op),
    .acc_en  (acc_en),
    .reload  (reload),
    .capture (capture),
    .state_q (state_q)
  );

  mmod_fold #(.OPW(OPW), .S(S), .ACCW(ACCW), .MAXSUM(MAXSUM)) u_fold (
    .clk     (clk),
    .rst     (rst),
    .load_op (load_op),
    .reload  (reload),
    .acc_en  (acc_en),
    .operand (operand),
    .sum_q   (sum_q),
    .last    (last),
    .over_d  (over_d)
  );

  mmod_result #(.S(S), .ACCW(ACCW)) u_res (
    .clk       (clk),
    .rst       (rst),
    .capture   (capture),
    .sum       (sum_q),
    .done      (done),
    .remainder (remainder)
  );

  AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> (state_q == ST_FIN)); // R4

endmodule

// File: tb/tb_mersenne_mod_seq.sv
module tb_mersenne_mod_seq;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] operand = '0;

  logic       done2, done3, done5;
  logic [1:0] rem2;
  logic [2:0] rem3;
  logic [4:0] rem5;

  int n_checks = 0;
  int n_fail   = 0;

  logic       done_v [3];
  logic [4:0] rem_v  [3];
  int         first_v [3];
  int         cnt_v   [3];
  logic [4:0] got_v   [3];

  always #(CLK_P/2) clk = ~clk;

  mersenne_mod_seq #(.OPW(32), .S(2)) dut (
    .clk(clk), .rst(rst), .start(start), .operand(operand),
    .done(done2), .remainder(rem2));
  mersenne_mod_seq #(.OPW(32), .S(3)) dut_s3 (
    .clk(clk), .rst(rst), .start(start), .operand(operand),
    .done(done3), .remainder(rem3));
  mersenne_mod_seq #(.OPW(32), .S(5)) dut_s5 (
    .clk(clk), .rst(rst), .start(start), .operand(operand),
    .done(done5), .remainder(rem5));

  assign done_v[0] = done2;
  assign done_v[1] = done3;
  assign done_v[2] = done5;
  assign rem_v[0]  = {3'b000, rem2};
  assign rem_v[1]  = {2'b00, rem3};
  assign rem_v[2]  = rem5;

  function automatic int divisor(input int k);
    case (k)
      0: return 3;
      1: return 7;
      default: return 31;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Runs one operand on all three units; optional second start while busy.
  task automatic run_op(input logic [31:0] op, input bit inject, input string req);
    @(negedge clk);
    operand = op;
    start   = 1'b1;
    for (int k = 0; k < 3; k++) begin
      first_v[k] = 0; cnt_v[k] = 0; got_v[k] = '0;
    end
    for (int i = 1; i <= 80; i++) begin
      @(negedge clk);
      if (i == 1) start = 1'b0;
      if (inject && i == 2) begin
        start   = 1'b1;
        operand = op ^ 32'h5A5A_5A5A;
      end else if (inject && i == 3) begin
        start = 1'b0;
      end
      for (int k = 0; k < 3; k++) begin
        if (done_v[k]) begin
          cnt_v[k]++;
          if (first_v[k] == 0) first_v[k] = i;
          got_v[k] = rem_v[k];
        end
      end
    end
    for (int k = 0; k < 3; k++) begin
      chk(cnt_v[k] == 1, inject ? "R5" : "R4", "done count", cnt_v[k], 1);
      chk(int'(got_v[k]) == int'(op % divisor(k)), req, "remainder",
          got_v[k], op % divisor(k));
      chk(rem_v[k] == got_v[k], "R7", "remainder held", rem_v[k], got_v[k]);
    end
  endtask

  task automatic test_reset();
    for (int k = 0; k < 3; k++) begin
      chk(done_v[k] == 1'b0, "R1", "done after reset", done_v[k], 0);
      chk(rem_v[k] == '0, "R1", "remainder after reset", rem_v[k], 0);
    end
  endtask

  task automatic test_zero();
    run_op(32'd0, 1'b0, "R8");
  endtask

  task automatic test_latency();
    run_op(32'd1, 1'b0, "R2");
    for (int k = 0; k < 3; k++)
      chk(first_v[k] == 3, "R6", "single digit latency", first_v[k], 3);
  endtask

  task automatic test_multiples();
    run_op(32'd651, 1'b0, "R3");        // 3*7*31
    run_op(32'd651 * 32'd1000, 1'b0, "R3");
    run_op(32'd3, 1'b0, "R3");
    run_op(32'd31, 1'b0, "R3");
  endtask

  task automatic test_boundaries();
    run_op(32'hFFFF_FFFF, 1'b0, "R2");
    run_op(32'h8000_0000, 1'b0, "R2");
    run_op(32'h7FFF_FFFF, 1'b0, "R2");
    run_op(32'd30, 1'b0, "R2");
  endtask

  task automatic test_random();
    for (int j = 0; j < 20; j++) run_op($urandom, 1'b0, "R2");
  endtask

  task automatic test_busy_start();
    run_op(32'hDEAD_BEEF, 1'b1, "R5");
    run_op(32'h1234_5678, 1'b1, "R5");
  endtask

  initial begin
    #(CLK_P * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_zero();
    test_latency();
    test_multiples();
    test_boundaries();
    test_busy_start();
    test_random();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule